// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a single burst request into the column address sequence that an SDRAM controller presents, one address per clock. A request carries the starting column and the mode fields in force: the burst-length code, the ordering bit (sequential or interleaved), the write-single bit, and whether the access is a write. From the following cycle on, the block emits one column per clock with a valid flag, and it marks the final beat with a last flag.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the naturally aligned block that holds the starting column. Sequential order counts upward and wraps inside that block. Interleaved order XORs the beat number into the low start bits. A full-page burst walks the whole row, wraps at the row end and runs until a stop input ends it. A new request always takes over from any burst in progress. Mode combinations that are not defined give a single access and raise an error flag.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and in the first cycle after it, col_valid, col_last and mode_err are all 0.
- R2: A request sampled with bst_start high at a clock edge makes col_valid high in the cycle after that edge, with col_out equal to start_col. Each later beat follows one clock after the previous one.
- R3: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. col_last is high on the final beat only, and col_valid is low in the cycle after the final beat unless a new request arrives.
- R4: With burst_type 0 and a fixed length N, beat k addresses (start_col with its low log2(N) bits replaced by (start_col + k) mod N). The upper bits never change, so 3 then 4,5,6,7,0,1,2 for N=8.
- R5: With burst_type 1 and a fixed length N, beat k addresses start_col XOR k, confined to the low log2(N) bits (5,4,7,6,1,0,3,2 for N=8 from 5). For N=1, burst_type has no effect and the single beat is start_col.
- R6: Length code 3'b111 with burst_type 0 is a full-page burst. Beat k addresses (start_col + k) mod 2^COL_W, so it wraps from the top column to 0. col_last is never high, and the burst continues until it is stopped.
- R7: bst_stop sampled high at an edge, with bst_start low, ends the burst. The beat on the bus in that cycle is still valid, and col_valid is low from the next cycle.
- R8: When is_write and write_single are both 1, the burst is a single beat at start_col whatever the length code. Reads, and writes with write_single 0, use the programmed length.
- R9: Length codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with burst_type 1, give a single beat at start_col with mode_err and col_last both high on that beat. mode_err is low on every other cycle.
- R10: bst_start sampled high while a burst is active aborts that burst. The next cycle carries beat 0 of the new request at its start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bst_start | input | 1 | Burst request pulse |
| start_col | input | COL_W | Starting column of the request |
| is_write | input | 1 | Request is a write |
| len_code | input | 3 | Burst-length code |
| burst_type | input | 1 | 0 sequential, 1 interleaved |
| write_single | input | 1 | Force writes to a single beat |
| bst_stop | input | 1 | End the running burst |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | col_out carries a beat |
| col_last | output | 1 | Current beat is the final one of a fixed burst |
| mode_err | output | 1 | Current beat comes from an undefined mode combination |

## Verification
The bench builds the block with its default COL_W of 8, so a full page is 256 columns. At that width, a directed full-page run of 260 beats crosses the wrap from column 255 to 0 inside one short test. Random requests over the full 8-bit column range place starts at every offset inside the 2-, 4- and 8-beat blocks, so both orderings reach every wrap point. They also mix in stops, mid-burst restarts and reserved codes.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  // widest fixed block is 8 beats -> 3 low column bits
  localparam int LG_MAX = 3;

  typedef enum logic [2:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_PAGE  = 3'b111
  } len_code_e;

  typedef struct packed {
    logic [1:0] lg;    // log2 of fixed block size
    logic       full;  // full-page walk
    logic       ilv;   // interleaved ordering
    logic       err;   // undefined mode combination
  } burst_cfg_t;

  // low-bit mask of a block of 2**lg beats
  function automatic logic [LG_MAX-1:0] blk_mask(input logic [1:0] lg);
    logic [LG_MAX-1:0] m;
    m = '0;
    for (int i = 0; i < LG_MAX; i++) m[i] = (i < int'(lg));
    return m;
  endfunction

endpackage

// File: rtl/sdb_mode_decode.sv
module sdb_mode_decode
  import sdb_pkg::*;
(
  input  logic [2:0]  len_code,
  input  logic        burst_type,
  input  logic        is_write,
  input  logic        write_single,
  output burst_cfg_t  cfg
);

  logic code_known;
  logic bad_combo;
  logic force_one;

  always_comb begin
    code_known = 1'b0;
    case (len_code)
      BL_ONE, BL_TWO, BL_FOUR, BL_EIGHT, BL_PAGE: code_known = 1'b1;
      default: code_known = 1'b0;
    endcase
  end

  assign bad_combo = !code_known || (len_code == BL_PAGE && burst_type);
  assign force_one = bad_combo || (is_write && write_single);

  always_comb begin
    cfg.err  = bad_combo;
    cfg.ilv  = burst_type;
    cfg.full = 1'b0;
    cfg.lg   = 2'd0;
    if (!force_one) begin
      if (len_code == BL_PAGE) cfg.full = 1'b1;
      else                     cfg.lg   = len_code[1:0];
    end
  end

endmodule

// File: rtl/sdb_beat_ctrl.sv
module sdb_beat_ctrl
  import sdb_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bst_start,
  input  logic             bst_stop,
  input  burst_cfg_t       cfg_in,
  input  logic [COL_W-1:0] col_in,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output burst_cfg_t       cfg_q,
  output logic [COL_W-1:0] col_q,
  output logic             at_last
);

  logic [COL_W-1:0] last_beat;
  logic             end_now;

  assign last_beat = COL_W'(blk_mask(cfg_q.lg));
  assign at_last   = active && !cfg_q.full && (beat == last_beat);
  assign end_now   = bst_stop || at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
      cfg_q  <= '0;
      col_q  <= '0;
    end else if (bst_start) begin
      active <= 1'b1;
      beat   <= '0;
      cfg_q  <= cfg_in;
      col_q  <= col_in;
    end else if (active) begin
      if (end_now) active <= 1'b0;
      else         beat   <= beat + 1'b1;
    end
  end

  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bst_start |=> (active && beat == '0)); // R10
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bst_stop && !bst_start) |=> !active); // R7
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && !bst_start) |=> !active); // R3
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !end_now && !bst_start) |=> (active && beat == $past(beat) + 1'b1)); // R2

endmodule

// File: rtl/sdb_addr_map.sv
module sdb_addr_map
  import sdb_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] col_q,
  input  logic [COL_W-1:0] beat,
  input  burst_cfg_t       cfg_q,
  output logic [COL_W-1:0] col_out
);

  // in-block offset: sum or XOR, kept to LG_MAX bits, wrap by mask
  function automatic logic [LG_MAX-1:0] blk_offset(
    input logic [LG_MAX-1:0] st,
    input logic [LG_MAX-1:0] bt,
    input logic              ilv);
    return ilv ? (st ^ bt) : (st + bt);
  endfunction

  logic [LG_MAX-1:0] mask;
  logic [LG_MAX-1:0] low;
  logic [COL_W-1:0]  page_sum;

  assign mask     = blk_mask(cfg_q.lg);
  assign low      = blk_offset(col_q[LG_MAX-1:0], beat[LG_MAX-1:0], cfg_q.ilv);
  assign page_sum = col_q + beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    if (i < LG_MAX) begin : g_low
      assign col_out[i] = cfg_q.full ? page_sum[i] : (mask[i] ? low[i] : col_q[i]);
    end else begin : g_high
      assign col_out[i] = cfg_q.full ? page_sum[i] : col_q[i];
    end
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdb_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bst_start,
  input  logic [COL_W-1:0] start_col,
  input  logic             is_write,
  input  logic [2:0]       len_code,
  input  logic             burst_type,
  input  logic             write_single,
  input  logic             bst_stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic             mode_err
);

  burst_cfg_t       cfg_new;
  burst_cfg_t       cfg_q;
  logic             active;
  logic             at_last;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] col_q;

  sdb_mode_decode u_dec (
    .len_code     (len_code),
    .burst_type   (burst_type),
    .is_write     (is_write),
    .write_single (write_single),
    .cfg          (cfg_new)
  );

  sdb_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bst_start (bst_start),
    .bst_stop  (bst_stop),
    .cfg_in    (cfg_new),
    .col_in    (start_col),
    .active    (active),
    .beat      (beat),
    .cfg_q     (cfg_q),
    .col_q     (col_q),
    .at_last   (at_last)
  );

  sdb_addr_map #(.COL_W(COL_W)) u_map (
    .col_q   (col_q),
    .beat    (beat),
    .cfg_q   (cfg_q),
    .col_out (col_out)
  );

  assign col_valid = active;
  assign col_last  = at_last;
  assign mode_err  = active && cfg_q.err;

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (col_last && col_out == col_q)); // R9
  AST_FULL_NOLAST: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && cfg_q.full) |-> !col_last); // R6
  AST_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !cfg_q.full) |-> (col_out[COL_W-1:LG_MAX] == col_q[COL_W-1:LG_MAX])); // R4
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    bst_start |=> (col_valid && col_out == $past(start_col))); // R2

endmodule

// File: tb/sim_sdram_burst_colgen.sv
module sim_sdram_burst_colgen;

  localparam int COL_W = 8;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bst_start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             is_write = 1'b0;
  logic [2:0]       len_code = 3'd0;
  logic             burst_type = 1'b0;
  logic             write_single = 1'b0;
  logic             bst_stop = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid, col_last, mode_err;

  always #4 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bst_start(bst_start), .start_col(start_col),
    .is_write(is_write), .len_code(len_code), .burst_type(burst_type),
    .write_single(write_single), .bst_stop(bst_stop), .col_out(col_out),
    .col_valid(col_valid), .col_last(col_last), .mode_err(mode_err)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  bit m_act = 0;
  int m_st = 0, m_beat = 0, m_len = 1; // m_len 0 = full page
  bit m_ilv = 0, m_err = 0;

  function automatic int ref_col(int st, int bt, int n, bit ilv);
    int off, blk;
    if (n == 0) return (st + bt) % PAGE;
    off = st % n;
    blk = st - off;
    if (ilv) return blk + (off ^ bt);
    return blk + ((off + bt) % n);
  endfunction

  function automatic bit ref_bad(int code, bit bt);
    return (code == 4 || code == 5 || code == 6 || (code == 7 && bt));
  endfunction

  task automatic model_edge(bit s, int c, bit w, int code, bit bt, bit ws, bit sp);
    if (s) begin
      m_act = 1; m_beat = 0; m_st = c; m_ilv = bt;
      m_err = ref_bad(code, bt);
      if (m_err || (w && ws)) m_len = 1;
      else if (code == 7)     m_len = 0;
      else                    m_len = 1 << code;
    end else if (m_act) begin
      if (sp) m_act = 0;
      else if (m_len != 0 && m_beat == m_len - 1) m_act = 0;
      else m_beat = m_beat + 1;
    end
  endtask

  task automatic check(string tag);
    bit ev, el, ee;
    int ec;
    ev = m_act;
    el = m_act && m_len != 0 && m_beat == m_len - 1;
    ee = m_act && m_err;
    ec = ref_col(m_st, m_beat, m_len, m_ilv);
    n_vec++;
    if (col_valid !== ev || col_last !== el || mode_err !== ee ||
        (ev && int'(col_out) != ec)) begin
      n_bad++;
      $display("FAIL %s: valid/last/err/col = %0b/%0b/%0b/%0d expected %0b/%0b/%0b/%0d",
               tag, col_valid, col_last, mode_err, col_out, ev, el, ee, ec);
    end
  endtask

  // drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(bit s, int c, bit w, int code, bit bt, bit ws, bit sp, string tag);
    bst_start = s; start_col = COL_W'(c); is_write = w; len_code = 3'(code);
    burst_type = bt; write_single = ws; bst_stop = sp;
    @(posedge clk);
    model_edge(s, c, w, code, bt, ws, sp);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic burst(int c, bit w, int code, bit bt, bit ws, int cycles, string tag);
    cyc(1, c, w, code, bt, ws, 0, tag);
    idle(cycles, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1");

    // lengths
    burst(8'h10, 0, 0, 0, 0, 2, "R3");
    burst(8'h21, 0, 1, 0, 0, 3, "R3");
    burst(8'h32, 0, 2, 0, 0, 5, "R3");
    burst(8'h40, 0, 3, 0, 0, 9, "R3");
    // sequential wrap in block
    burst(8'h03, 0, 3, 0, 0, 9, "R4");
    burst(8'hFE, 0, 2, 0, 0, 5, "R4");
    // interleaved, and type ignored at length 1
    burst(8'h05, 0, 3, 1, 0, 9, "R5");
    burst(8'h03, 0, 2, 1, 0, 5, "R5");
    burst(8'h37, 0, 0, 1, 0, 2, "R5");
    // full page wrap then stop
    cyc(1, 8'hFC, 0, 7, 0, 0, 0, "R6");
    idle(260, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, "R7");
    idle(2, "R7");
    // stop inside a fixed burst
    cyc(1, 8'h50, 0, 3, 0, 0, 0, "R7");
    idle(2, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, "R7");
    idle(2, "R7");
    // write-single
    burst(8'h66, 1, 3, 0, 1, 3, "R8");
    burst(8'h66, 0, 3, 0, 1, 9, "R8");
    burst(8'h66, 1, 2, 0, 0, 5, "R8");
    // undefined combos
    burst(8'h71, 0, 4, 0, 0, 2, "R9");
    burst(8'h72, 0, 5, 1, 0, 2, "R9");
    burst(8'h73, 0, 6, 0, 0, 2, "R9");
    burst(8'h74, 0, 7, 1, 0, 2, "R9");
    // restart mid-burst
    cyc(1, 8'h80, 0, 3, 0, 0, 0, "R10");
    idle(2, "R10");
    cyc(1, 8'h9B, 0, 2, 1, 0, 0, "R10");
    idle(5, "R10");

    // random mix
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5D3A);
      for (int i = 0; i < 6000; i++) begin
        bit s, sp;
        s  = m_act ? ($urandom_range(0, 7) == 0) : ($urandom_range(0, 1) == 0);
        sp = ($urandom_range(0, 19) == 0);
        cyc(s, $urandom_range(0, PAGE - 1), 1'($urandom_range(0, 1)),
            $urandom_range(0, 7), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), sp, "R2");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule